// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

An eight-pin general-purpose I/O port controlled through four byte-wide registers: an output latch, a direction mask, a pullup mask and a slew-limit mask. A small synchronous register bus (address, write strobe, write data, combinational read data) reaches those registers. Each pin presents four pad controls: the value to drive, an output enable, a pullup request and a slew-limit request. The raw pin levels come back through a two-flop synchronizer. Reads of the output latch return those synchronized levels for input pins.

Two on-chip peripherals can take over some of the pins. While its enable input is high, a UART owns pin 0 (transmit) and pin 1 (receive), and a two-wire serial bus owns pin 2 (data) and pin 3 (clock). A pin that a peripheral owns takes its drive value and enable from that peripheral, and its direction bit has no effect on the drive. The pullup and slew masks still shape the pad. The UART wins any pin that both peripherals would claim. The synchronized levels of the receive, data and clock pins are passed back to the peripherals.

Top module: `gpio_port`

## Requirements
- R1: After reset, all four registers read 0 and no pin is driven, pulled up or slew-limited while neither peripheral is enabled.
- R2: The pullup mask (offset 1), the slew mask (offset 2) and the direction mask (offset 3) read back the last value written. The output latch (offset 0) reads back its written value on every pin whose direction bit is 1.
- R3: A read of offset 0 returns, for each pin whose direction bit is 0, the pin level sampled through the two-flop synchronizer. A change on a pin appears in reads two rising edges later.
- R4: A write to offset 0 latches all eight bits whatever the direction mask holds. A pin with direction 0 is not driven. Setting its direction bit to 1 later drives the latched value.
- R5: On a pin no peripheral owns, pin_out equals the latch bit and pin_oe equals the direction bit.
- R6: pin_pu is 1 exactly when the pullup bit is 1, the direction bit is 0 and the pin is not being driven.
- R7: pin_slew is 1 exactly when the slew bit is 1 and the pin is being driven.
- R8: With uart_en high, pin 0 drives uart_txd with enable 1 and pin 1 is undriven, whatever their direction bits are.
- R9: With twi_en high and uart_en low, pin 2 takes twi_sda_out/twi_sda_oe and pin 3 takes twi_scl_out/twi_scl_oe, whatever their direction bits are.
- R10: Offsets 4 to 7 read as 0, and writes to them change no register.
- R11: uart_rxd, twi_sda_in and twi_scl_in equal the levels of pins 1, 2 and 3 as sampled two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Per-pin drive value |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pullup request |
| pin_slew | output | 8 | Per-pin slew-limit request |
| uart_en | input | 1 | UART claims pins 0 and 1 |
| uart_txd | input | 1 | UART transmit value |
| uart_rxd | output | 1 | Synchronized pin 1 level |
| twi_en | input | 1 | Serial bus claims pins 2 and 3 |
| twi_sda_out | input | 1 | Data line drive value |
| twi_sda_oe | input | 1 | Data line drive enable |
| twi_scl_out | input | 1 | Clock line drive value |
| twi_scl_oe | input | 1 | Clock line drive enable |
| twi_sda_in | output | 1 | Synchronized pin 2 level |
| twi_scl_in | output | 1 | Synchronized pin 3 level |

## Verification
The bench sweeps 32 arithmetic combinations of direction, latch, pullup, slew and pin values. Because each combination differs in many bits, a read that mixes up the latch and the pin source, or a pad control that ignores its direction gating, gives a different byte. Separate patterns keep each peripheral enabled while its pins' direction bits are set first one way and then the other. This separates ownership from ordinary register control. Pin steps sampled after one edge and after two edges tell a correct two-stage delay from a shorter or longer one. Writes of all ones to the unmapped offsets show whether any decode aliasing reaches a real register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPINS  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_PULL = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_SLEW = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(3);

    localparam int UART_TX_PIN = 0;
    localparam int UART_RX_PIN = 1;
    localparam int SDA_PIN     = 2;
    localparam int SCL_PIN     = 3;

    typedef struct packed {
        logic [NPINS-1:0] data;
        logic [NPINS-1:0] pull;
        logic [NPINS-1:0] slew;
        logic [NPINS-1:0] dir;
    } port_regs_t;

    typedef struct packed {
        logic val;
        logic oe;
    } drive_t;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_UART = 2'd1,
        OWN_TWI  = 2'd2
    } owner_e;

    function automatic logic uart_pin(input int pin);
        return (pin == UART_TX_PIN) || (pin == UART_RX_PIN);
    endfunction

    function automatic logic twi_pin(input int pin);
        return (pin == SDA_PIN) || (pin == SCL_PIN);
    endfunction

    // UART has precedence over the serial bus on any shared pin.
    function automatic owner_e resolve_owner(input int pin, input logic u_en, input logic t_en);
        if (u_en && uart_pin(pin))
            return OWN_UART;
        else if (t_en && twi_pin(pin))
            return OWN_TWI;
        else
            return OWN_NONE;
    endfunction

    // Ordinary register-controlled drive of one pin.
    function automatic drive_t reg_drive(input logic latch_bit, input logic dir_bit);
        drive_t d;
        d.val = latch_bit;
        d.oe  = dir_bit;
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int W  = NPINS,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_sync,
    output port_regs_t    regs,
    output logic [W-1:0]  rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            case (addr)
                OFS_DATA: regs.data <= wdata;
                OFS_PULL: regs.pull <= wdata;
                OFS_SLEW: regs.slew <= wdata;
                OFS_DIR:  regs.dir  <= wdata;
                default: ;
            endcase
        end
    end

    // Output pins report the latch, input pins report the synchronized level.
    logic [W-1:0] data_view;
    assign data_view = (regs.dir & regs.data) | (~regs.dir & pin_sync);

    always_comb begin
        case (addr)
            OFS_DATA: rdata = data_view;
            OFS_PULL: rdata = regs.pull;
            OFS_SLEW: rdata = regs.slew;
            OFS_DIR:  rdata = regs.dir;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pkg::*;
#(
    parameter int W = NPINS
) (
    input  port_regs_t   regs,
    input  logic         uart_en,
    input  logic         uart_txd,
    input  logic         twi_en,
    input  logic         twi_sda_out,
    input  logic         twi_sda_oe,
    input  logic         twi_scl_out,
    input  logic         twi_scl_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu,
    output logic [W-1:0] pin_slew
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        owner_e own;
        drive_t drv;

        assign own = resolve_owner(i, uart_en, twi_en);

        always_comb begin
            drv = reg_drive(regs.data[i], regs.dir[i]);
            case (own)
                OWN_UART: begin
                    if (i == UART_TX_PIN) begin
                        drv.val = uart_txd;
                        drv.oe  = 1'b1;
                    end else begin
                        drv.val = 1'b0;
                        drv.oe  = 1'b0;
                    end
                end
                OWN_TWI: begin
                    if (i == SDA_PIN) begin
                        drv.val = twi_sda_out;
                        drv.oe  = twi_sda_oe;
                    end else begin
                        drv.val = twi_scl_out;
                        drv.oe  = twi_scl_oe;
                    end
                end
                default: ;
            endcase
        end

        assign pin_out[i]  = drv.val;
        assign pin_oe[i]   = drv.oe;
        assign pin_pu[i]   = regs.pull[i] & ~regs.dir[i] & ~drv.oe;
        assign pin_slew[i] = regs.slew[i] & drv.oe;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pu,
    output logic [NPINS-1:0]  pin_slew,
    input  logic              uart_en,
    input  logic              uart_txd,
    output logic              uart_rxd,
    input  logic              twi_en,
    input  logic              twi_sda_out,
    input  logic              twi_sda_oe,
    input  logic              twi_scl_out,
    input  logic              twi_scl_oe,
    output logic              twi_sda_in,
    output logic              twi_scl_in
);
    localparam int SYNC_STAGES = 2;

    logic [NPINS-1:0] pin_sync;
    port_regs_t       regs;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_regfile #(.W(NPINS), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .regs     (regs),
        .rdata    (bus_rdata)
    );

    gpio_pad_mux #(.W(NPINS)) u_mux (
        .regs        (regs),
        .uart_en     (uart_en),
        .uart_txd    (uart_txd),
        .twi_en      (twi_en),
        .twi_sda_out (twi_sda_out),
        .twi_sda_oe  (twi_sda_oe),
        .twi_scl_out (twi_scl_out),
        .twi_scl_oe  (twi_scl_oe),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pin_pu      (pin_pu),
        .pin_slew    (pin_slew)
    );

    assign uart_rxd   = pin_sync[UART_RX_PIN];
    assign twi_sda_in = pin_sync[SDA_PIN];
    assign twi_scl_in = pin_sync[SCL_PIN];
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pin_pu,
    input logic [NPINS-1:0]  pin_slew,
    input logic              uart_en,
    input logic              uart_txd,
    input logic              uart_rxd,
    input logic              twi_en,
    input logic              twi_sda_oe,
    input logic              twi_scl_oe
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !uart_en && !twi_en) |-> (pin_oe == '0 && pin_pu == '0 && pin_slew == '0));

    p_pull_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_we) && $past(bus_addr) == OFS_PULL && bus_addr == OFS_PULL)
        |-> bus_rdata == $past(bus_wdata));

    p_dir_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_we) && $past(bus_addr) == OFS_DIR && bus_addr == OFS_DIR)
        |-> bus_rdata == $past(bus_wdata));

    p_pull_input_only_r6: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_oe) == '0);

    p_slew_driven_only_r7: assert property (@(posedge clk) disable iff (rst)
        (pin_slew & ~pin_oe) == '0);

    p_uart_owns_r8: assert property (@(posedge clk) disable iff (rst)
        uart_en |-> (pin_oe[UART_TX_PIN] && pin_out[UART_TX_PIN] == uart_txd && !pin_oe[UART_RX_PIN]));

    p_twi_owns_r9: assert property (@(posedge clk) disable iff (rst)
        (twi_en && !uart_en) |-> (pin_oe[SDA_PIN] == twi_sda_oe && pin_oe[SCL_PIN] == twi_scl_oe));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > OFS_DIR) |-> bus_rdata == '0);

    p_rx_latency_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> uart_rxd == $past(pin_in[UART_RX_PIN], 2));
endmodule

bind gpio_port gpio_port_chk i_chk (.*);

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in;
    logic [7:0] pin_out, pin_oe, pin_pu, pin_slew;
    logic       uart_en, uart_txd, uart_rxd;
    logic       twi_en, twi_sda_out, twi_sda_oe, twi_scl_out, twi_scl_oe;
    logic       twi_sda_in, twi_scl_in;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_slew(pin_slew),
        .uart_en(uart_en), .uart_txd(uart_txd), .uart_rxd(uart_rxd),
        .twi_en(twi_en), .twi_sda_out(twi_sda_out), .twi_sda_oe(twi_sda_oe),
        .twi_scl_out(twi_scl_out), .twi_scl_oe(twi_scl_oe),
        .twi_sda_in(twi_sda_in), .twi_scl_in(twi_scl_in)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
        uart_en = 1'b0; uart_txd = 1'b0; twi_en = 1'b0;
        twi_sda_out = 1'b0; twi_sda_oe = 1'b0; twi_scl_out = 1'b0; twi_scl_oe = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 8'h00);
        end
        check("R1 oe", pin_oe, 8'h00);
        check("R1 pu", pin_pu, 8'h00);
        check("R1 slew", pin_slew, 8'h00);

        // R2 readback of pull, slew, dir
        for (int o = 1; o < 4; o++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] w;
                w = 8'(k * 53 + o * 29 + 1);
                wr(3'(o), w);
                rd(3'(o), v);
                check("R2 readback", v, w);
            end
        end
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h69);
        rd(3'd0, v);
        check("R2 latch readback", v, 8'h69);

        // R3 R5 R6 R7 sweep
        for (int k = 0; k < 32; k++) begin
            logic [7:0] dv, lv, pv, uv, sv;
            dv = 8'(k * 37) ^ 8'hC3;
            lv = 8'(k * 91 + 7);
            pv = ~8'(k * 23);
            uv = 8'(k * 13) ^ 8'h96;
            sv = 8'(k * 71 + 3);
            wr(3'd3, dv); wr(3'd0, lv); wr(3'd1, uv); wr(3'd2, sv);
            set_pins(pv);
            rd(3'd0, v);
            check("R3 data read", v, (dv & lv) | (~dv & pv));
            check("R5 out", pin_out, lv);
            check("R5 oe", pin_oe, dv);
            check("R6 pu", pin_pu, uv & ~dv);
            check("R7 slew", pin_slew, sv & dv);
        end

        // R3 latency: one edge is too early, two edges suffice
        wr(3'd3, 8'h00);
        set_pins(8'h00);
        @(negedge clk); pin_in = 8'hB7;
        @(negedge clk);
        rd(3'd0, v);
        check("R3 one edge", v, 8'h00);
        @(negedge clk);
        rd(3'd0, v);
        check("R3 two edges", v, 8'hB7);

        // R4 latch while input, then drive
        set_pins(8'h00);
        wr(3'd0, 8'hA5);
        check("R4 undriven", pin_oe, 8'h00);
        rd(3'd0, v);
        check("R4 reads pin", v, 8'h00);
        wr(3'd3, 8'hFF);
        check("R4 driven", pin_oe, 8'hFF);
        check("R4 value", pin_out, 8'hA5);
        rd(3'd0, v);
        check("R4 latch read", v, 8'hA5);

        // R8 UART ownership
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd0, 8'h00);
        uart_en = 1'b1;
        for (int d = 0; d < 2; d++) begin
            logic [7:0] dv;
            dv = d ? 8'hFF : 8'h00;
            wr(3'd3, dv);
            for (int t = 0; t < 2; t++) begin
                uart_txd = t[0];
                #1;
                check("R8 oe", pin_oe, {dv[7:2], 2'b01});
                check("R8 out", pin_out, {6'b0, 1'b0, t[0]});
                check("R6 uart pu", pin_pu, {~dv[7:2], ~dv[1], 1'b0});
                check("R7 uart slew", pin_slew, {dv[7:2], 2'b01});
            end
        end
        uart_en = 1'b0; uart_txd = 1'b0;

        // R9 serial-bus ownership
        twi_en = 1'b1;
        for (int d = 0; d < 2; d++) begin
            logic [7:0] dv;
            dv = d ? 8'hFF : 8'h00;
            wr(3'd3, dv);
            for (int c = 0; c < 16; c++) begin
                logic [7:0] eo, eoe;
                twi_sda_out = c[0]; twi_sda_oe = c[1];
                twi_scl_out = c[2]; twi_scl_oe = c[3];
                #1;
                eo  = {4'b0, c[2], c[0], 2'b00};
                eoe = {dv[7:4], c[3], c[1], dv[1:0]};
                check("R9 out", pin_out, eo);
                check("R9 oe", pin_oe, eoe);
                check("R6 twi pu", pin_pu, ~dv & ~eoe);
                check("R7 twi slew", pin_slew, eoe);
            end
        end
        twi_en = 1'b0;

        // R10 unmapped offsets
        wr(3'd3, 8'h0F); wr(3'd0, 8'h5A); wr(3'd1, 8'h3C); wr(3'd2, 8'hC3);
        set_pins(8'h00);
        for (int a = 4; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd(3'(a), v);
            check("R10 zero read", v, 8'h00);
        end
        rd(3'd0, v); check("R10 data kept", v, 8'h0A);
        rd(3'd1, v); check("R10 pull kept", v, 8'h3C);
        rd(3'd2, v); check("R10 slew kept", v, 8'hC3);
        rd(3'd3, v); check("R10 dir kept", v, 8'h0F);

        // R11 peripheral receive paths
        for (int p = 0; p < 8; p++) begin
            logic [7:0] pv;
            pv = {4'b0, 3'(p), 1'b0};
            set_pins(pv);
            check("R11 rx", {5'b0, twi_scl_in, twi_sda_in, uart_rxd}, 8'(p));
        end
        @(negedge clk); pin_in = 8'h00;
        @(negedge clk);
        check("R11 one edge", {5'b0, twi_scl_in, twi_sda_in, uart_rxd}, 8'h07);
        @(negedge clk);
        check("R11 two edges", {5'b0, twi_scl_in, twi_sda_in, uart_rxd}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule